// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside the write port of a byte-wide parallel flash array and turns streams of bus writes into one-cycle operation strobes. Every operation is guarded by a fixed two-write unlock pattern followed by a command byte. Some operations then take a target write, and the erase and lock family repeats the unlock pair before a final selector write. The array, the program and erase timers, and the pin-level bus timing all live outside this block. It only sees one `wr_en` pulse per bus write, with the latched address and data.

The decoder recognises these operations:

- byte program, which passes out the target address and data;
- sector erase, which passes out the sector address;
- chip erase;
- boot-region lock enable;
- identification mode entry and exit.

It keeps an identification-mode flag. While the flag is set, an identification read port returns the manufacturer code, the device code and the lock status at small offsets. While the external timers report a program or erase in progress, every write is dropped and the sequence position is left where it was.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After a synchronous reset the following hold: all strobes are low, `id_mode` is 0, `id_data` is 8'h00, and the sequence position is idle, so a later 2AAA←55 write does not count as an unlock step.
- R2: The writes 5555←AA, 2AAA←55, 5555←A0, then any address/data cause a one-cycle `prog_stb` on the clock after the fourth write. On that cycle `cmd_addr` and `cmd_data` equal that fourth write's address and data. None of the first three writes raises any strobe.
- R3: The six writes 5555←AA, 2AAA←55, 5555←80, 5555←AA, 2AAA←55, 5555←10 raise `chip_erase_stb` on the clock after the sixth write.
- R4: The same five-write prefix followed by 30 written to any address raises `sect_erase_stb`, with `cmd_addr` equal to that sixth address.
- R5: The same five-write prefix followed by 5555←40 raises `lock_stb`.
- R6: The writes 5555←AA, 2AAA←55, 5555←90 raise `id_enter_stb` on the clock after the third write, and `id_mode` is 1 one clock later.
- R7: `id_exit_stb` is raised in either of two cases, and `id_mode` returns to 0 one clock after the strobe:
  - the three writes 5555←AA, 2AAA←55, 5555←F0;
  - a single write of F0 to any address while the sequence is idle.
- R8: Unlock and command addresses are matched on address bits 14..0 only; bits above 14 are ignored.
- R9: Any write that does not fit the expected next step returns the sequence to idle and raises no strobe. That write is consumed and does not itself start a new sequence.
- R10: A write made while `erase_busy` or `prog_busy` is 1 raises no strobe, leaves `id_mode` unchanged and leaves the sequence position unchanged.
- R11: While `id_mode` is 1, `id_data` is selected by `rd_addr[1:0]`:
  - 0 gives 8'h1F;
  - 1 gives 8'h08;
  - 2 gives `{7'b0, lock_state}`;
  - 3 gives 8'h00.
  While `id_mode` is 0, `id_data` is 8'h00.
- R12: Each strobe is exactly one clock wide, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle pulse per bus write |
| wr_addr | input | ADDR_W | Address of the bus write |
| wr_data | input | 8 | Data of the bus write |
| erase_busy | input | 1 | An erase is running; writes are dropped |
| prog_busy | input | 1 | A byte program is running; writes are dropped |
| rd_addr | input | ADDR_W | Read address; bits 1..0 select the identification field |
| lock_state | input | 1 | Current boot-region lock status |
| prog_stb | output | 1 | Byte program request |
| sect_erase_stb | output | 1 | Sector erase request |
| chip_erase_stb | output | 1 | Chip erase request |
| lock_stb | output | 1 | Boot-region lock enable request |
| id_enter_stb | output | 1 | Identification mode entered |
| id_exit_stb | output | 1 | Identification mode left |
| cmd_addr | output | ADDR_W | Target address for program or sector erase |
| cmd_data | output | 8 | Byte to program |
| id_mode | output | 1 | Identification mode flag |
| id_data | output | 8 | Identification read data |

## Verification
Timing of each result, counted from the rising edge that samples a write:
- A strobe, together with `cmd_addr` and `cmd_data`, is registered once, so it is visible during the cycle that follows that edge.
- `id_mode` passes one more register and follows the strobe by one clock.
- `id_data` is combinational from `id_mode`, `rd_addr` and `lock_state`.

How the bench keeps to that timing:
- It drives every write on a falling edge and reads the strobes on the next falling edge.
- It reads `id_mode` one falling edge after that.
- It checks on the falling edge after the strobe that the strobe has dropped.
- Dropped writes and broken sequences are judged from the strobes and from the way a later, valid write is decoded.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_BYTE_A = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B = 8'h55;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_ID_IN   = 8'h90;
    localparam logic [7:0] OP_ID_OUT  = 8'hF0;
    localparam logic [7:0] SEL_CHIP   = 8'h10;
    localparam logic [7:0] SEL_SECTOR = 8'h30;
    localparam logic [7:0] SEL_LOCK   = 8'h40;

    localparam logic [7:0] MFR_CODE = 8'h1F;
    localparam logic [7:0] DEV_CODE = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3
    } seq_state_t;

    typedef struct packed {
        logic prog;
        logic sect;
        logic chip;
        logic lock;
        logic id_in;
        logic id_out;
    } cmd_stb_t;

    function automatic logic key_match(input logic [KEY_W-1:0] a,
                                       input logic [KEY_W-1:0] key);
        return a == key;
    endfunction

endpackage

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              hold,
    output cmd_stb_t          stb,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        tgt_data
);

    seq_state_t st_q, st_d;
    cmd_stb_t   stb_d;
    logic       at_a, at_b, take;

    assign at_a = key_match(wr_addr[KEY_W-1:0], KEY_ADDR_A);
    assign at_b = key_match(wr_addr[KEY_W-1:0], KEY_ADDR_B);
    assign take = wr_en && !hold;

    always_comb begin
        st_d  = st_q;
        stb_d = '0;
        if (take) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (at_a && wr_data == KEY_BYTE_A) st_d = ST_KEY1;
                    else if (wr_data == OP_ID_OUT)     stb_d.id_out = 1'b1;
                end
                ST_KEY1: st_d = (at_b && wr_data == KEY_BYTE_B) ? ST_KEY2 : ST_IDLE;
                ST_KEY2: begin
                    st_d = ST_IDLE;
                    if (at_a) begin
                        case (wr_data)
                            OP_PROGRAM: st_d = ST_PROG;
                            OP_ERASE:   st_d = ST_ERS1;
                            OP_ID_IN:   stb_d.id_in  = 1'b1;
                            OP_ID_OUT:  stb_d.id_out = 1'b1;
                            default:    st_d = ST_IDLE;
                        endcase
                    end
                end
                ST_PROG: begin
                    st_d       = ST_IDLE;
                    stb_d.prog = 1'b1;
                end
                ST_ERS1: st_d = (at_a && wr_data == KEY_BYTE_A) ? ST_ERS2 : ST_IDLE;
                ST_ERS2: st_d = (at_b && wr_data == KEY_BYTE_B) ? ST_ERS3 : ST_IDLE;
                ST_ERS3: begin
                    st_d = ST_IDLE;
                    if (wr_data == SEL_SECTOR)             stb_d.sect = 1'b1;
                    else if (at_a && wr_data == SEL_CHIP)  stb_d.chip = 1'b1;
                    else if (at_a && wr_data == SEL_LOCK)  stb_d.lock = 1'b1;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            stb      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
        end else begin
            st_q <= st_d;
            stb  <= stb_d;
            if (stb_d.prog || stb_d.sect) tgt_addr <= wr_addr;
            if (stb_d.prog)               tgt_data <= wr_data;
        end
    end

endmodule

// File: rtl/cmd_id_flag.sv
module cmd_id_flag
    import cmdseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmd_stb_t stb,
    output logic     id_mode
);

    always_ff @(posedge clk) begin
        if (rst)             id_mode <= 1'b0;
        else if (stb.id_in)  id_mode <= 1'b1;
        else if (stb.id_out) id_mode <= 1'b0;
    end

endmodule

// File: rtl/cmd_id_view.sv
module cmd_id_view
    import cmdseq_pkg::*;
(
    input  logic       id_mode,
    input  logic [1:0] offset,
    input  logic       lock_state,
    output logic [7:0] id_data
);

    always_comb begin
        id_data = 8'h00;
        if (id_mode) begin
            case (offset)
                2'd0:    id_data = MFR_CODE;
                2'd1:    id_data = DEV_CODE;
                2'd2:    id_data = {7'b0, lock_state};
                default: id_data = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_busy,
    input  logic              prog_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              lock_state,
    output logic              prog_stb,
    output logic              sect_erase_stb,
    output logic              chip_erase_stb,
    output logic              lock_stb,
    output logic              id_enter_stb,
    output logic              id_exit_stb,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              id_mode,
    output logic [7:0]        id_data
);

    cmd_stb_t stb;

    cmd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hold     (erase_busy | prog_busy),
        .stb      (stb),
        .tgt_addr (cmd_addr),
        .tgt_data (cmd_data)
    );

    cmd_id_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .id_mode (id_mode)
    );

    cmd_id_view u_view (
        .id_mode    (id_mode),
        .offset     (rd_addr[1:0]),
        .lock_state (lock_state),
        .id_data    (id_data)
    );

    assign prog_stb       = stb.prog;
    assign sect_erase_stb = stb.sect;
    assign chip_erase_stb = stb.chip;
    assign lock_stb       = stb.lock;
    assign id_enter_stb   = stb.id_in;
    assign id_exit_stb    = stb.id_out;

endmodule

// File: rtl/cmd_seq_checker.sv
module cmd_seq_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic erase_busy,
    input logic prog_busy,
    input logic prog_stb,
    input logic sect_erase_stb,
    input logic chip_erase_stb,
    input logic lock_stb,
    input logic id_enter_stb,
    input logic id_exit_stb,
    input logic id_mode
);

    logic [5:0] s;
    assign s = {prog_stb, sect_erase_stb, chip_erase_stb, lock_stb, id_enter_stb, id_exit_stb};

    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0(s)); // R12
    AST_STB_ONE_WIDE: assert property (@(posedge clk) disable iff (rst) (s != 6'd0) |=> (s == 6'd0)); // R12
    AST_NO_WRITE_NO_STB: assert property (@(posedge clk) disable iff (rst) !wr_en |=> (s == 6'd0)); // R9
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst) (erase_busy || prog_busy) |=> (s == 6'd0)); // R10
    AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst) (erase_busy || prog_busy) |=> ##1 $stable(id_mode)); // R10
    AST_ID_SET: assert property (@(posedge clk) disable iff (rst) id_enter_stb |=> id_mode); // R6
    AST_ID_CLEAR: assert property (@(posedge clk) disable iff (rst) id_exit_stb |=> !id_mode); // R7

endmodule

bind cmd_seq_decoder cmd_seq_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .erase_busy     (erase_busy),
    .prog_busy      (prog_busy),
    .prog_stb       (prog_stb),
    .sect_erase_stb (sect_erase_stb),
    .chip_erase_stb (chip_erase_stb),
    .lock_stb       (lock_stb),
    .id_enter_stb   (id_enter_stb),
    .id_exit_stb    (id_exit_stb),
    .id_mode        (id_mode)
);

// File: tb/cmd_seq_decoder_bench.sv
module cmd_seq_decoder_bench;

    localparam int AW = 18;
    localparam logic [5:0] V_PROG = 6'b100000, V_SECT = 6'b010000, V_CHIP = 6'b001000,
                           V_LOCK = 6'b000100, V_IDIN = 6'b000010, V_IDOUT = 6'b000001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic erase_busy = 1'b0, prog_busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic lock_state = 1'b0;
    logic prog_stb, sect_erase_stb, chip_erase_stb, lock_stb, id_enter_stb, id_exit_stb;
    logic [AW-1:0] cmd_addr;
    logic [7:0] cmd_data, id_data;
    logic id_mode;

    int checks = 0, fails = 0;
    logic [5:0] got;
    logic exp_mode = 1'b0;

    always #10 clk = ~clk;

    cmd_seq_decoder #(.ADDR_W(AW)) u_cmd_seq_decoder (.*);

    function automatic logic [5:0] stbv();
        return {prog_stb, sect_erase_stb, chip_erase_stb, lock_stb, id_enter_stb, id_exit_stb};
    endfunction

    function automatic logic [AW-1:0] hi(input logic [14:0] low);
        return {3'($urandom_range(0, 7)), low};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic busy = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        erase_busy = busy; prog_busy = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; erase_busy = 1'b0;
        got = stbv();
    endtask

    task automatic unlock();
        wr(hi(15'h5555), 8'hAA); chk(got == 0, "R2 step1", got, 0);
        wr(hi(15'h2AAA), 8'h55); chk(got == 0, "R2 step2", got, 0);
    endtask

    task automatic six(input logic [AW-1:0] a, input logic [7:0] d);
        unlock(); wr(hi(15'h5555), 8'h80);
        unlock(); wr(a, d);
    endtask

    task automatic gap_check(input string req);
        @(negedge clk);
        chk(stbv() == 0, req, stbv(), 0);
        chk(id_mode == exp_mode, req, id_mode, exp_mode);
    endtask

    // Drive one complete command of the given kind and check its strobe.
    task automatic run_kind(input int k);
        logic [AW-1:0] a = AW'($urandom);
        logic [7:0] d = 8'($urandom);
        logic [5:0] e;
        case (k)
            0: begin unlock(); wr(hi(15'h5555), 8'hA0); wr(a, d); e = V_PROG;
                     chk(cmd_addr == a && cmd_data == d, "R2 target", {cmd_addr, cmd_data}, {a, d}); end
            1: begin six(a, 8'h30); e = V_SECT;
                     chk(cmd_addr == a, "R4 sector addr", cmd_addr, a); end
            2: begin six(hi(15'h5555), 8'h10); e = V_CHIP; end
            3: begin six(hi(15'h5555), 8'h40); e = V_LOCK; end
            4: begin unlock(); wr(hi(15'h5555), 8'h90); e = V_IDIN; exp_mode = 1'b1; end
            default: begin
                if (d[0]) begin unlock(); wr(hi(15'h5555), 8'hF0); end
                else wr(a, 8'hF0);
                e = V_IDOUT; exp_mode = 1'b0;
            end
        endcase
        chk(got == e, "R2-R7 strobe kind", got, e);
        gap_check("R12 one clock wide");
    endtask

    initial begin
        void'($urandom(32'd7421));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(stbv() == 0 && !id_mode && id_data == 0, "R1 reset outputs", {stbv(), id_mode, id_data}, 0);
        rst = 1'b0;
        wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(18'h01000, 8'h12);
        chk(got == 0, "R1 idle after reset", got, 0);

        // R2 directed program
        unlock(); wr(18'h05555, 8'hA0); chk(got == 0, "R2 step3", got, 0);
        wr(18'h3C001, 8'h5A);
        chk(got == V_PROG, "R2 program", got, V_PROG);
        chk(cmd_addr == 18'h3C001 && cmd_data == 8'h5A, "R2 target", {cmd_addr, cmd_data}, {18'h3C001, 8'h5A});
        gap_check("R12 prog width");

        // R3 / R4 / R5
        six(18'h05555, 8'h10); chk(got == V_CHIP, "R3 chip erase", got, V_CHIP);
        six(18'h3A123, 8'h30); chk(got == V_SECT && cmd_addr == 18'h3A123, "R4 sector erase", {got, cmd_addr}, {V_SECT, 18'h3A123});
        six(18'h05555, 8'h40); chk(got == V_LOCK, "R5 lock enable", got, V_LOCK);
        six(18'h05554, 8'h10); chk(got == 0, "R9 chip selector at wrong address", got, 0);

        // R6 / R11
        unlock(); wr(18'h05555, 8'h90); chk(got == V_IDIN, "R6 id enter", got, V_IDIN);
        @(negedge clk); chk(id_mode == 1'b1, "R6 id_mode set", id_mode, 1);
        exp_mode = 1'b1;
        for (int o = 0; o < 4; o++) begin
            for (int l = 0; l < 2; l++) begin
                logic [7:0] ev;
                rd_addr = {16'($urandom), 2'(o)};
                lock_state = l[0];
                ev = (o == 0) ? 8'h1F : (o == 1) ? 8'h08 : (o == 2) ? {7'b0, l[0]} : 8'h00;
                #1 chk(id_data == ev, "R11 id readout", id_data, ev);
            end
        end

        // R10: busy writes are dropped, mode and sequence kept
        wr(18'h01234, 8'hF0, 1'b1); chk(got == 0, "R10 busy F0 dropped", got, 0);
        @(negedge clk); chk(id_mode == 1'b1, "R10 id_mode kept", id_mode, 1);
        unlock(); wr(18'h05555, 8'h11, 1'b1); wr(18'h05555, 8'hA0); wr(18'h00042, 8'hC3);
        chk(got == V_PROG && cmd_data == 8'hC3, "R10 sequence position kept", {got, cmd_data}, {V_PROG, 8'hC3});

        // R7 single-write exit at any address
        wr(18'h2F0F0, 8'hF0); chk(got == V_IDOUT, "R7 single F0 exit", got, V_IDOUT);
        @(negedge clk); chk(id_mode == 1'b0, "R7 id_mode cleared", id_mode, 0);
        exp_mode = 1'b0;
        rd_addr = '0; #1 chk(id_data == 8'h00, "R11 data zero outside id mode", id_data, 0);
        unlock(); wr(18'h05555, 8'h90); @(negedge clk);
        unlock(); wr(18'h05555, 8'hF0); chk(got == V_IDOUT, "R7 three-write exit", got, V_IDOUT);
        @(negedge clk); chk(id_mode == 1'b0, "R7 id_mode cleared", id_mode, 0);

        // R8: upper address bits ignored
        wr(18'h15555, 8'hAA); wr(18'h3AAAA, 8'h55); wr(18'h25555, 8'hA0); wr(18'h00777, 8'h01);
        chk(got == V_PROG, "R8 upper bits ignored", got, V_PROG);
        wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00001, 8'h02);
        chk(got == 0, "R8 low bits compared", got, 0);

        // R9: broken sequences
        unlock(); wr(18'h05555, 8'h77); chk(got == 0, "R9 bad command", got, 0);
        wr(18'h00010, 8'h99); chk(got == 0, "R9 back to idle", got, 0);
        wr(18'h05555, 8'hAA); wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00003, 8'h04);
        chk(got == 0, "R9 breaking write consumed", got, 0);

        // Random commands mixed with stray writes
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                wr(AW'($urandom), 8'($urandom), 1'b1);
                chk(got == 0, "R10 random busy write", got, 0);
            end
            run_kind(int'($urandom_range(0, 5)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule